// File: doc/BRIEF.md
# Port Change Interrupt Unit

This unit sits between a small general-purpose I/O register block and the pads of eight I/O pins, split into two groups of four. Group A (bits 3:0) has open-drain pins and group B (bits 7:4) has push-pull pins. A direction bit per pin selects input or output. For output pins the unit produces the pad enable and pad data. For input pins it compares the synchronized pin level against a reference snapshot. Any mismatch on a watched pin latches a change flag, and the active-low interrupt output asserts.

The register interface issues `rd_ack_stb` together with `rd_grp` during the address acknowledge of a read. On that cycle the unit loads the selected group's snapshot from the current pin levels and clears only that group's flags. The new snapshot is presented on `snap_val`, and later changes are measured against it. A per-pin disable bit keeps a pin's flag clear, which avoids false interrupts while its direction is being changed. The only other thing that clears flags is the power-up reset. An abort of the serial interface is not wired to this unit, so it leaves the interrupt alone.

Top module: `io_change_irq`

## Requirements
- R1: A direction bit of 1 makes the pin an input. Its `pad_oe` bit is 0 and its `pad_do` bit is 0.
- R2: A pin whose direction bit is 0 never sets a change flag, whatever its level does. With every direction bit at 0, `irq_n` is 1 one cycle later.
- R3: A watched input pin is one with direction 1 and disable 0. When its level differs from its snapshot bit at a clock edge, `irq_n` goes to 0 after that edge. It stays 0 after the level returns to the snapshot value.
- R4: A pin whose `cfg_irq_off` bit is 1 keeps its flag clear. Toggling such a pin leaves `irq_n` at 1.
- R5: An edge with `rd_ack_stb`=1 and `rd_grp`=g (0 for group A, 1 for group B) clears the flags of group g only. Flags of the other group are kept.
- R6: On that same edge, the snapshot bits of group g load the current pin levels, and these appear on `snap_val`. A level that equals the new snapshot raises nothing. A change in any later cycle, including while the read byte is still being shifted out, is detected against the new snapshot.
- R7: Open-drain pins (group A): an output pin with register value 0 has `pad_oe`=1 and `pad_do`=0. An output pin with value 1 has `pad_oe`=0, so the pin is released.
- R8: Push-pull pins (group B): an output pin has `pad_oe`=1 and `pad_do` equal to its register value.
- R9: Asserting `rst_n`=0 clears all flags and snapshots. `irq_n` then reads 1 and `snap_val` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| pin_lvl | input | 8 | Synchronized pin levels |
| cfg_dir | input | 8 | Direction bits, 1 = input |
| cfg_irq_off | input | 8 | Per-pin change-detect disable, 1 = disabled |
| out_reg | input | 8 | Output register values |
| rd_ack_stb | input | 1 | Address-acknowledge strobe of a read |
| rd_grp | input | 1 | Group being read, 0 = A, 1 = B |
| snap_val | output | 8 | Snapshot returned to the register interface |
| pad_oe | output | 8 | Pad output enable |
| pad_do | output | 8 | Pad output data |
| irq_n | output | 1 | Interrupt, active low; the pad is open drain |

## Verification
The assertions assume that `pin_lvl` has already passed through a synchronizer and changes only between clock edges. They also assume that `rd_ack_stb` is a single-cycle strobe with a valid `rd_grp`. The bench meets these by driving every input on the falling clock edge. It raises the strobe for exactly one cycle and holds the group select steady while the strobe is high.

// File: rtl/io_irq_pkg.sv
package io_irq_pkg;
  typedef enum logic {DRV_OPEN_DRAIN = 1'b0, DRV_PUSH_PULL = 1'b1} drv_kind_e;
endpackage

// File: rtl/pad_ctrl.sv
module pad_ctrl
  import io_irq_pkg::*;
#(
  parameter int        PINS = 4,
  parameter drv_kind_e KIND = DRV_PUSH_PULL
) (
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] val,
  output logic [PINS-1:0] oe,
  output logic [PINS-1:0] dout
);
  // an output pin is one whose direction bit is clear
  function automatic logic [PINS-1:0] drive_en(input logic [PINS-1:0] d,
                                               input logic [PINS-1:0] v,
                                               input logic od);
    drive_en = od ? (~d & ~v) : ~d;
  endfunction

  generate
    if (KIND == DRV_OPEN_DRAIN) begin : g_od
      assign oe   = drive_en(dir, val, 1'b1);
      assign dout = '0;
    end else begin : g_pp
      assign oe   = drive_en(dir, val, 1'b0);
      assign dout = val & ~dir;
    end
  endgenerate

  // R1: input pins never drive
  always_comb a_r1_input_quiet : assert ((oe & dir) == '0);
endmodule

// File: rtl/chg_group.sv
module chg_group #(
  parameter int PINS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] dir,
  input  logic [PINS-1:0] off,
  input  logic            take,
  output logic [PINS-1:0] snap_q,
  output logic            any_flag
);
  logic [PINS-1:0] flag_q;
  logic [PINS-1:0] watch;
  logic [PINS-1:0] diff;

  function automatic logic [PINS-1:0] watched(input logic [PINS-1:0] d,
                                              input logic [PINS-1:0] o);
    watched = d & ~o;
  endfunction

  function automatic logic [PINS-1:0] mismatch(input logic [PINS-1:0] a,
                                               input logic [PINS-1:0] b);
    mismatch = a ^ b;
  endfunction

  assign watch = watched(dir, off);
  assign diff  = mismatch(lvl, snap_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= '0;
    end else if (take) begin
      snap_q <= lvl;
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q | diff) & watch;
    end
  end

  assign any_flag = |flag_q;

  // R6: read acknowledge loads the snapshot from the pins
  a_r6_snap_load : assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (snap_q == $past(lvl)));
  // R5: read acknowledge empties this group's flags
  a_r5_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flag_q == '0));
  // R4: unwatched pins hold their flag clear
  a_r4_unwatched_clear : assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(watch)) == '0));
  // R3: a latched flag survives while the pin stays watched
  a_r3_latch_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ((($past(flag_q) & $past(watch)) & ~flag_q) == '0));
endmodule

// File: rtl/io_change_irq.sv
module io_change_irq
  import io_irq_pkg::*;
#(
  parameter int PINS   = 4,
  parameter int GROUPS = 2,
  parameter logic [GROUPS-1:0] OD_MAP = 2'b01,
  localparam int W    = PINS * GROUPS,
  localparam int SELW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    pin_lvl,
  input  logic [W-1:0]    cfg_dir,
  input  logic [W-1:0]    cfg_irq_off,
  input  logic [W-1:0]    out_reg,
  input  logic            rd_ack_stb,
  input  logic [SELW-1:0] rd_grp,
  output logic [W-1:0]    snap_val,
  output logic [W-1:0]    pad_oe,
  output logic [W-1:0]    pad_do,
  output logic            irq_n
);
  logic [GROUPS-1:0] grp_flag;
  logic [GROUPS-1:0] grp_take;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    localparam int LO = g * PINS;
    assign grp_take[g] = rd_ack_stb && (rd_grp == SELW'(g));

    chg_group #(.PINS(PINS)) i_chg (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_lvl[LO +: PINS]),
      .dir      (cfg_dir[LO +: PINS]),
      .off      (cfg_irq_off[LO +: PINS]),
      .take     (grp_take[g]),
      .snap_q   (snap_val[LO +: PINS]),
      .any_flag (grp_flag[g])
    );

    if (OD_MAP[g]) begin : g_od
      pad_ctrl #(.PINS(PINS), .KIND(DRV_OPEN_DRAIN)) i_pad (
        .dir (cfg_dir[LO +: PINS]), .val (out_reg[LO +: PINS]),
        .oe  (pad_oe[LO +: PINS]),  .dout(pad_do[LO +: PINS]));
    end else begin : g_pp
      pad_ctrl #(.PINS(PINS), .KIND(DRV_PUSH_PULL)) i_pad (
        .dir (cfg_dir[LO +: PINS]), .val (out_reg[LO +: PINS]),
        .oe  (pad_oe[LO +: PINS]),  .dout(pad_do[LO +: PINS]));
    end
  end

  assign irq_n = ~|grp_flag;

  // R2: with no inputs configured, the interrupt is released next cycle
  a_r2_outputs_silent : assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir == '0) |=> irq_n);
  // R5: a read strobe touches a single group
  a_r5_one_group : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_take));
endmodule

// File: tb/test_io_change_irq.sv
module test_io_change_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_lvl = '0, cfg_dir = 8'hFF, cfg_irq_off = '0, out_reg = '0;
  logic       rd_ack_stb = 1'b0;
  logic [0:0] rd_grp = '0;
  logic [7:0] snap_val, pad_oe, pad_do;
  logic       irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  io_change_irq i_io_change_irq (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .cfg_dir(cfg_dir),
    .cfg_irq_off(cfg_irq_off), .out_reg(out_reg), .rd_ack_stb(rd_ack_stb),
    .rd_grp(rd_grp), .snap_val(snap_val), .pad_oe(pad_oe), .pad_do(pad_do),
    .irq_n(irq_n));

  // dir, out, expected oe, expected do
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00},
    {8'h00, 8'hFF, 8'hF0, 8'hF0},
    {8'hFF, 8'hA5, 8'h00, 8'h00},
    {8'h0F, 8'h5A, 8'hF0, 8'h50},
    {8'hF0, 8'h36, 8'h09, 8'h00},
    {8'hA5, 8'hC3, 8'h58, 8'h40}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic rd(input logic g);
    rd_grp = g; rd_ack_stb = 1'b1; tick(); rd_ack_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R9: reset state
    chk("R9 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R9 snap_val", snap_val, 8'h00);
    rst_n = 1'b1; tick();

    // R1 R7 R8: drive table
    foreach (VEC[k]) begin
      cfg_dir = VEC[k][31:24]; out_reg = VEC[k][23:16]; #1;
      chk("R1/R7/R8 pad_oe", pad_oe, VEC[k][15:8]);
      chk("R1/R7/R8 pad_do", pad_do, VEC[k][7:0]);
    end
    cfg_dir = 8'hFF; out_reg = '0; tick(); tick();
    chk("R9 idle irq_n", {7'd0, irq_n}, 8'h01);

    // R3: change on A0 latches, survives return
    pin_lvl = 8'h01; tick();
    chk("R3 assert", {7'd0, irq_n}, 8'h00);
    pin_lvl = 8'h00; tick();
    chk("R3 latched", {7'd0, irq_n}, 8'h00);
    // R5: reading B keeps A's flag
    rd(1'b1);
    chk("R5 other group kept", {7'd0, irq_n}, 8'h00);
    rd(1'b0);
    chk("R5 own group cleared", {7'd0, irq_n}, 8'h01);

    // R4: disabled pin ignored
    cfg_irq_off = 8'h02; pin_lvl = 8'h02; tick(); tick();
    chk("R4 masked", {7'd0, irq_n}, 8'h01);
    pin_lvl = 8'h00; cfg_irq_off = 8'h00; tick();

    // R2: output pin ignored
    cfg_dir = 8'hFB; pin_lvl = 8'h04; tick(); tick();
    chk("R2 output pin", {7'd0, irq_n}, 8'h01);
    pin_lvl = 8'h00; cfg_dir = 8'hFF; tick();

    // R6: snapshot taken at the acknowledge, later change detected
    pin_lvl = 8'h03; rd(1'b0);
    chk("R6 snap_val", snap_val, 8'h03);
    tick();
    chk("R6 equal to snapshot", {7'd0, irq_n}, 8'h01);
    pin_lvl = 8'h01; tick();
    chk("R6 later change", {7'd0, irq_n}, 8'h00);
    rd(1'b0);

    // R5: group B change not cleared by reading A
    pin_lvl = 8'h21; tick();
    chk("R3 group B", {7'd0, irq_n}, 8'h00);
    rd(1'b0);
    chk("R5 A read keeps B", {7'd0, irq_n}, 8'h00);
    rd(1'b1);
    chk("R6 snap B", snap_val, 8'h21);
    chk("R5 B cleared", {7'd0, irq_n}, 8'h01);

    // R9: reset clears a pending interrupt
    pin_lvl = 8'h00; tick();
    chk("R9 pre-reset", {7'd0, irq_n}, 8'h00);
    rst_n = 1'b0; #1;
    chk("R9 reset irq", {7'd0, irq_n}, 8'h01);
    chk("R9 reset snap", snap_val, 8'h00);
    tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule